// File: doc/BRIEF.md
# Guard Key Detect Arbiter

This block sits after the per-key detection stage of a capacitive touch engine. Each acquisition cycle, that stage delivers one raw detect flag per key. The arbiter turns these flags into the key states that are reported. A configuration byte can name one key as a guard, usually a larger and more sensitive pad around the others. When the guard is armed and touched, it masks every other key. This keeps a hand that brushes across the panel from registering as key presses.

The guard does not take over at once. A key that is already reporting when the guard key is touched keeps reporting. The guard stays pending until every such key has released, and only then becomes active. While the guard is pending, no key that was not already reporting may start reporting. Once the guard is active, only the guard key is reported. When the guard key's raw flag clears, all keys follow their raw flags again in that same evaluation.

The outputs are registered. They change only on the clock edge where the cycle-complete strobe is high.

Top module: `guard_detect_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `key_out` is all zeros and `guard_active` is 0.
- R2: With `guard_en` low, a strobe copies `raw_det` to `key_out` bit for bit and clears `guard_active`.
- R3: With the guard armed, suppose a strobe sees the guard key's raw flag set, no other key is reporting, and the guard is not yet active. Then `key_out` becomes the one-hot bit at index `guard_sel` (bit i is key i), and `guard_active` becomes 1.
- R4: With the guard armed, suppose a strobe sees the guard key's raw flag set while some other key is reporting and its raw flag is still set. Then those keys stay reported, the guard key's bit stays 0 and `guard_active` stays 0. The guard becomes active at the first strobe after all such keys have released.
- R5: While `guard_active` is 1, a strobe that still sees the guard key's raw flag set reports only the guard key, whatever the other raw flags are.
- R6: A strobe that sees the guard key's raw flag clear sets `guard_active` to 0 and copies `raw_det` to `key_out` in that same strobe.
- R7: A `guard_sel` value of NUM_KEYS or more disarms the guard, so behaviour is the same as R2 even with `guard_en` high.
- R8: Without a strobe, `key_out` and `guard_active` hold their values whatever the inputs do.
- R9: While the guard is pending (R4), a key whose raw flag is set but which was not reporting before that strobe is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycle_done | input | 1 | Acquisition-cycle-complete strobe, one clock wide |
| raw_det | input | NUM_KEYS | Raw per-key detect flags, bit i is key i |
| guard_en | input | 1 | Guard option enable from the setup byte |
| guard_sel | input | SEL_W | Index of the guard key |
| key_out | output | NUM_KEYS | Reported per-key detect states |
| guard_active | output | 1 | High while the guard masks the other keys |

## Verification
The register that matters is the set of keys reported in the previous cycle. A wrong value there changes the choice between holding a key, leaving the guard pending or activating the guard. The error shows on `key_out` and `guard_active` on the very next strobe. The stimulus therefore runs the guard through all of its states in sequence: idle, active, released, pending with a held key, a new key blocked while pending, and activation after the held key releases. A stale or mis-latched previous state would then give a wrong guard bit or a leaked key at the following strobe.

// File: rtl/gk_pkg.sv
package gk_pkg;
    // How a strobe resolves the reported vector
    typedef enum logic [1:0] {
        GK_PASS  = 2'd0,  // raw flags copied through
        GK_PEND  = 2'd1,  // guard touched, held keys still reporting
        GK_GUARD = 2'd2   // guard owns the outputs
    } gk_mode_e;
endpackage

// File: rtl/gk_decode.sv
module gk_decode #(
    parameter int unsigned NUM_KEYS = 11,
    parameter int unsigned SEL_W    = 4
) (
    input  logic                guard_en,
    input  logic [SEL_W-1:0]    guard_sel,
    output logic [NUM_KEYS-1:0] guard_mask,
    output logic                guard_armed
);
    // Index in range of populated keys?
    assign guard_armed = guard_en && (32'(guard_sel) < NUM_KEYS);

    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_mask
        assign guard_mask[i] = (guard_sel == SEL_W'(i));
    end

    always_comb begin
        if (guard_armed) begin
            AST_MASK_ONEHOT: assert ($onehot0(guard_mask) && guard_mask != '0); // R3
        end
    end
endmodule

// File: rtl/gk_arbiter.sv
module gk_arbiter
    import gk_pkg::*;
#(
    parameter int unsigned NUM_KEYS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cycle_done,
    input  logic [NUM_KEYS-1:0] raw_det,
    input  logic [NUM_KEYS-1:0] guard_mask,
    input  logic                guard_armed,
    output logic [NUM_KEYS-1:0] key_out,
    output logic                guard_active
);
    typedef struct packed {
        logic [NUM_KEYS-1:0] keys;
        logic                active;
    } arb_state_t;

    arb_state_t          state_d, state_q;
    gk_mode_e            mode;
    logic [NUM_KEYS-1:0] held_keys;
    logic                guard_touch;

    assign guard_touch = |(raw_det & guard_mask);
    assign held_keys   = state_q.keys & raw_det & ~guard_mask;

    // Resolve the mode for this evaluation
    always_comb begin
        if (!guard_armed || !guard_touch) begin
            mode = GK_PASS;
        end else if (state_q.active) begin
            mode = GK_GUARD;
        end else if (held_keys != '0) begin
            mode = GK_PEND;
        end else begin
            mode = GK_GUARD;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (cycle_done) begin
            unique case (mode)
                GK_PASS: begin
                    state_d.keys   = raw_det;
                    state_d.active = 1'b0;
                end
                GK_PEND: begin
                    state_d.keys   = held_keys;
                    state_d.active = 1'b0;
                end
                default: begin
                    state_d.keys   = guard_mask;
                    state_d.active = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign key_out      = state_q.keys;
    assign guard_active = state_q.active;

    AST_BYPASS_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && !guard_armed) |=> (key_out == $past(raw_det) && !guard_active)); // R2

    AST_ACTIVE_MASKS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        guard_active |-> ((key_out & ~$past(guard_mask)) == '0)); // R5

    AST_HELD_BLOCKS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && guard_armed && guard_touch && !guard_active
         && ((key_out & raw_det & ~guard_mask) != '0)) |=> !guard_active); // R4

    AST_PEND_NO_NEW_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && guard_armed && guard_touch && !guard_active
         && ((key_out & raw_det & ~guard_mask) != '0))
        |=> ((key_out & ~$past(key_out)) == '0)); // R9

    AST_RELEASE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && !guard_touch) |=> (!guard_active && key_out == $past(raw_det))); // R6

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_done |=> ($stable(key_out) && $stable(guard_active))); // R8
endmodule

// File: rtl/guard_detect_arbiter.sv
module guard_detect_arbiter #(
    parameter int unsigned NUM_KEYS = 11,
    parameter int unsigned SEL_W    = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cycle_done,
    input  logic [NUM_KEYS-1:0] raw_det,
    input  logic                guard_en,
    input  logic [SEL_W-1:0]    guard_sel,
    output logic [NUM_KEYS-1:0] key_out,
    output logic                guard_active
);
    logic [NUM_KEYS-1:0] guard_mask;
    logic                guard_armed;

    gk_decode #(
        .NUM_KEYS (NUM_KEYS),
        .SEL_W    (SEL_W)
    ) u_decode (
        .guard_en    (guard_en),
        .guard_sel   (guard_sel),
        .guard_mask  (guard_mask),
        .guard_armed (guard_armed)
    );

    gk_arbiter #(
        .NUM_KEYS (NUM_KEYS)
    ) u_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .cycle_done   (cycle_done),
        .raw_det      (raw_det),
        .guard_mask   (guard_mask),
        .guard_armed  (guard_armed),
        .key_out      (key_out),
        .guard_active (guard_active)
    );

    AST_OUT_RANGE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && guard_en && 32'(guard_sel) >= NUM_KEYS) |=> !guard_active); // R7
endmodule

// File: tb/sim_guard_detect_arbiter.sv
module sim_guard_detect_arbiter;
    localparam int unsigned NK = 11;
    localparam int unsigned SW = 4;
    localparam int NV = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cycle_done = 1'b0;
    logic [NK-1:0] raw_det = '0;
    logic          guard_en = 1'b0;
    logic [SW-1:0] guard_sel = '0;
    logic [NK-1:0] key_out;
    logic          guard_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    guard_detect_arbiter #(.NUM_KEYS(NK), .SEL_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .cycle_done(cycle_done), .raw_det(raw_det),
        .guard_en(guard_en), .guard_sel(guard_sel),
        .key_out(key_out), .guard_active(guard_active)
    );

    // {req, en, sel, raw, exp_keys, exp_active}
    localparam logic [31:0] VEC [NV] = '{
        {4'd2, 1'b0, 4'd3,  11'h005, 11'h005, 1'b0}, // R2 disabled pass-through
        {4'd6, 1'b1, 4'd3,  11'h000, 11'h000, 1'b0}, // R6 armed, idle
        {4'd3, 1'b1, 4'd3,  11'h008, 11'h008, 1'b1}, // R3 guard alone
        {4'd5, 1'b1, 4'd3,  11'h00C, 11'h008, 1'b1}, // R5 key2 masked
        {4'd6, 1'b1, 4'd3,  11'h004, 11'h004, 1'b0}, // R6 guard released
        {4'd4, 1'b1, 4'd3,  11'h00C, 11'h004, 1'b0}, // R4 key2 held
        {4'd9, 1'b1, 4'd3,  11'h01C, 11'h004, 1'b0}, // R9 key4 blocked
        {4'd4, 1'b1, 4'd3,  11'h018, 11'h008, 1'b1}, // R4 activation after release
        {4'd6, 1'b1, 4'd3,  11'h000, 11'h000, 1'b0}, // R6
        {4'd7, 1'b1, 4'd12, 11'h40C, 11'h40C, 1'b0}, // R7 index out of range
        {4'd7, 1'b1, 4'd11, 11'h7FF, 11'h7FF, 1'b0}, // R7 index == NUM_KEYS
        {4'd3, 1'b1, 4'd10, 11'h400, 11'h400, 1'b1}, // R3 top key as guard
        {4'd5, 1'b1, 4'd10, 11'h401, 11'h400, 1'b1}, // R5
        {4'd2, 1'b0, 4'd10, 11'h401, 11'h401, 1'b0}  // R2
    };

    task automatic check(input int req, input logic [NK-1:0] exp_k, input logic exp_a);
        checks++;
        if (key_out !== exp_k || guard_active !== exp_a) begin
            fails++;
            $display("FAIL R%0d: key_out=%h active=%b expected key_out=%h active=%b",
                     req, key_out, guard_active, exp_k, exp_a);
        end
    endtask

    task automatic strobe(input logic en, input logic [SW-1:0] sel, input logic [NK-1:0] raw);
        @(negedge clk);
        guard_en = en; guard_sel = sel; raw_det = raw; cycle_done = 1'b1;
        @(negedge clk);
        cycle_done = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, '0, 1'b0); // R1 during reset
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(1, '0, 1'b0); // R1 after release

        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i][27], VEC[i][26:23], VEC[i][22:12]);
            check(int'(VEC[i][31:28]), VEC[i][11:1], VEC[i][0]);
        end

        // R8: inputs move without a strobe
        strobe(1'b1, 4'd3, 11'h008); // guard active, key_out 0x008
        @(negedge clk);
        raw_det = 11'h7F0; guard_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(8, 11'h008, 1'b1);

        // R6 guard release restores raw in the same strobe
        strobe(1'b1, 4'd3, 11'h0F0);
        check(6, 11'h0F0, 1'b0);

        // R1 mid-run reset clears state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        check(1, '0, 1'b0);
        rst_n = 1'b1;

        // R3 after reset: key0 as guard
        strobe(1'b1, 4'd0, 11'h001);
        check(3, 11'h001, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule